// File: doc/BRIEF.md
# Reloadable Ratio Clock Divider

This block derives a slower clock from its input clock by an integer ratio held in an active register. Software never writes that register directly. It writes a candidate ratio into a staging field, and the candidate is promoted only when a reload is requested: the channel's force bit must be set at the moment a global trigger bit goes from 0 to 1. A promoted ratio waits for the end of the output period that is running, so a change of rate never produces a shortened pulse.

The register port is a simple synchronous interface with byte address, write data, write strobe and combinational read data. It runs on the same clock as the divider. The divided output is gated by an enable bit. The block has one channel, and that channel has index 1. Only the ratios 4, 5, 6 and 8 are legal.

Top module: `clkdiv_reload`

## Requirements
- R1: After reset the active ratio is 4, both registers read 0, and `clk_out` is low.
- R2: The control register is at byte address 0x0. Bits [8:0] and bit 25 are stored there, and every other bit reads 0. The ratio register is at byte address 0x8. Only bits [13:8] are stored there, and every other bit reads 0. Any other address reads 0.
- R3: A write to the ratio field only stages a value. The running output keeps the active ratio.
- R4: A reload occurs only on a 0-to-1 change of control bit 8 while control bit 1 (the force bit of channel 1) is 1. A rising trigger with the force bit at 0 causes no reload. Setting the force bit while the trigger is already held at 1 also causes no reload.
- R5: While the output runs, a reloaded ratio takes effect only after the current period has completed in full.
- R6: A staged value other than 4, 5, 6 or 8 is discarded at reload, and the active ratio is kept.
- R7: With active ratio N and the output enabled, each period of `clk_out` is N input cycles long. It is low for N - floor(N/2) cycles and then high for floor(N/2) cycles.
- R8: While enable bit 25 is 0, `clk_out` is low, including when enable is cleared during the high phase. Each time enable is set, a fresh period starts with its low phase.
- R9: Clearing control bits [8:0] after a reload leaves the active ratio unchanged.
- R10: A reload made while the output is disabled takes effect at once, so the next enable uses the new ratio.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock for the divider and the register port |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 4 | Byte address of the register access |
| wr_en | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| clk_out | output | 1 | Divided, enable-gated clock |

## Verification
Two events can fall on the same edge: a reload request and the period boundary where a pending ratio is applied. In one case the trigger write lands one cycle before the last count of a running ratio-4 period. In the same case, the write that clears the request bits arrives on the exact edge where the swap to ratio 6 happens. The scoreboard holds a cycle-exact expected waveform: one complete ratio-4 period followed by ratio-6 periods. A truncated period, an early swap, or a ratio lost when the bits are cleared all show up as a mismatch. Disabling the output during the high phase is judged against the same waveform.

// File: rtl/clkdiv_reload.sv
module clkdiv_reload #(
  parameter int ADDR_W = 4,
  parameter int CH     = 1,
  parameter int RW     = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              clk_out
);
  localparam int EN_BIT   = 24 + CH;
  localparam int TRIG_BIT = 8;
  localparam int R_LSB    = 8 * CH;
  localparam logic [ADDR_W-1:0] CTRL_ADR  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] RATIO_ADR = ADDR_W'(8);
  localparam logic [RW-1:0] RESET_RATIO = RW'(4);

  logic [8:0]    req_q;
  logic          en_q, trig_d_q, pend_q;
  logic [RW-1:0] stage_q, act_q, pend_r_q, cnt_q;

  wire wr_ctrl  = wr_en && (addr == CTRL_ADR);
  wire wr_ratio = wr_en && (addr == RATIO_ADR);
  wire legal    = (stage_q == RW'(4)) || (stage_q == RW'(5)) ||
                  (stage_q == RW'(6)) || (stage_q == RW'(8));
  wire reload   = req_q[TRIG_BIT] && !trig_d_q && req_q[CH];
  wire last     = (cnt_q == act_q - RW'(1));
  wire swap     = pend_q && (!en_q || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q    <= '0;
      en_q     <= 1'b0;
      stage_q  <= '0;
      trig_d_q <= 1'b0;
    end else begin
      trig_d_q <= req_q[TRIG_BIT];
      if (wr_ctrl) begin
        req_q <= wdata[8:0];
        en_q  <= wdata[EN_BIT];
      end
      if (wr_ratio) stage_q <= wdata[R_LSB +: RW];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q   <= 1'b0;
      pend_r_q <= RESET_RATIO;
      act_q    <= RESET_RATIO;
      cnt_q    <= '0;
    end else begin
      if (reload && legal) begin
        pend_q   <= 1'b1;
        pend_r_q <= stage_q;
      end else if (swap) begin
        pend_q <= 1'b0;
      end
      if (swap) act_q <= pend_r_q;
      if (!en_q || last) cnt_q <= '0;
      else               cnt_q <= cnt_q + RW'(1);
    end
  end

  assign clk_out = en_q && (cnt_q >= (act_q - (act_q >> 1)));

  always_comb begin
    rdata = '0;
    if (addr == CTRL_ADR) begin
      rdata[8:0]    = req_q;
      rdata[EN_BIT] = en_q;
    end else if (addr == RATIO_ADR) begin
      rdata[R_LSB +: RW] = stage_q;
    end
  end
endmodule

module clkdiv_reload_chk #(
  parameter int RW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [RW-1:0] act,
  input logic [RW-1:0] cnt,
  input logic          clk_out
);
  AST_RATIO_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (act == RW'(4)) || (act == RW'(5)) || (act == RW'(6)) || (act == RW'(8))); // R6
  AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !clk_out); // R8
  AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en) |-> !clk_out); // R8
  AST_NO_RUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (en && cnt != act - RW'(1)) |=> $stable(act)); // R5
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> cnt < act); // R7
endmodule

bind clkdiv_reload clkdiv_reload_chk #(.RW(RW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en_q), .act(act_q), .cnt(cnt_q), .clk_out(clk_out)
);

// File: tb/clkdiv_reload_tb.sv
module clkdiv_reload_tb;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic clk_out;
  int n_chk = 0, n_bad = 0;
  bit exp_q[$];
  string tag_q[$];

  localparam logic [31:0] EN = 32'h0200_0000, TRG = 32'h100, FRC = 32'h2;

  clkdiv_reload u_dut (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
                       .wdata(wdata), .rdata(rdata), .clk_out(clk_out));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      bit e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      n_chk++;
      if (clk_out !== e) begin
        n_bad++;
        $display("FAIL %s clk_out actual=%b expected=%b at %0t", t, clk_out, e, $time);
      end
    end
  end

  task automatic chk(string t, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", t, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(posedge clk); #2;
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, logic [31:0] exp, string t);
    addr = a; #1;
    chk(t, rdata, exp);
  endtask

  task automatic push_bit(bit v, string t);
    exp_q.push_back(v);
    tag_q.push_back(t);
  endtask

  task automatic push_period(int n, int reps, string t);
    for (int r = 0; r < reps; r++)
      for (int i = 0; i < n; i++) push_bit(i >= n - n / 2, t);
  endtask

  task automatic drain();
    wait (exp_q.size() == 0);
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(20ns * 100000);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    // R1 reset state
    rd(4'h0, 32'h0, "R1 ctrl");
    rd(4'h8, 32'h0, "R1 ratio");
    chk("R1 out low", {31'b0, clk_out}, 32'h0);
    wr(4'h0, EN);
    push_period(4, 2, "R1/R7 ratio4");
    drain();
    wr(4'h0, 32'h0);

    // R3 staging alone does nothing
    wr(4'h8, 32'h0000_0600);
    rd(4'h8, 32'h0000_0600, "R3/R2 ratio readback");
    wr(4'h0, EN);
    push_period(4, 2, "R3 staged only");
    drain();
    wr(4'h0, 32'h0);

    // R5/R9 reload while running, clear coinciding with swap edge
    wr(4'h0, EN);
    push_period(4, 1, "R5 old period whole");
    push_period(6, 4, "R5/R9 ratio6");
    wr(4'h0, EN | TRG | FRC);
    wr(4'h0, EN);
    rd(4'h0, EN, "R2/R9 ctrl after clear");
    drain();
    wr(4'h0, 32'h0);

    // R8 disable during high phase, restart low
    wr(4'h0, EN);
    for (int i = 0; i < 4; i++) push_bit(i >= 3, "R8 restart low");
    for (int i = 0; i < 4; i++) push_bit(1'b0, "R8 forced low");
    repeat (2) @(posedge clk);
    wr(4'h0, 32'h0);
    drain();

    // R10 reload while disabled, odd ratio R7
    wr(4'h8, 32'h0000_0500);
    wr(4'h0, TRG | FRC);
    wr(4'h0, 32'h0);
    wr(4'h0, EN);
    push_period(5, 3, "R10/R7 ratio5");
    drain();
    wr(4'h0, 32'h0);

    // R6 illegal staged ratio
    wr(4'h8, 32'h0000_0700);
    wr(4'h0, TRG | FRC);
    wr(4'h0, 32'h0);
    wr(4'h0, EN);
    push_period(5, 2, "R6 ratio7 ignored");
    drain();
    wr(4'h0, 32'h0);

    // R7 ratio 8
    wr(4'h8, 32'h0000_0800);
    wr(4'h0, TRG | FRC);
    wr(4'h0, 32'h0);
    wr(4'h0, EN);
    push_period(8, 2, "R7 ratio8");
    drain();
    wr(4'h0, 32'h0);

    // R4 trigger without force, and force with trigger held
    wr(4'h8, 32'h0000_0400);
    wr(4'h0, TRG);
    wr(4'h0, 32'h0);
    wr(4'h0, EN);
    push_period(8, 1, "R4 no force");
    drain();
    wr(4'h0, TRG);
    wr(4'h0, TRG | FRC);
    wr(4'h0, 32'h0);
    wr(4'h0, EN);
    push_period(8, 1, "R4 trigger held");
    drain();
    wr(4'h0, 32'h0);

    // R2 unused bits and addresses
    wr(4'h0, 32'hFFFF_FFFF);
    rd(4'h0, 32'h0200_01FF, "R2 ctrl mask");
    wr(4'h8, 32'hFFFF_FFFF);
    rd(4'h8, 32'h0000_3F00, "R2 ratio mask");
    rd(4'h4, 32'h0, "R2 unmapped");
    finish_run();
  end
endmodule